// File: doc/BRIEF.md
# Open-Drain I2C Byte Master

This block runs the bus-level steps of an I2C master in hardware, one byte-level operation at a time. A host selects an operation (bus probe, START, STOP, byte write, byte read), a bus index, a byte to send and whether a received byte is to be acknowledged. It then pulses a start strobe and waits for the one-cycle done pulse. Results come back on a read-byte output and a single status bit. The status bit reports bus-ready for a probe and target-acknowledge for a write.

Every bus owns two adjacent bits in three packed vectors: line value, line enable and line readback. The clock line is driven actively. The data line emulates open drain: its value bit is held at 0, and only its enable is toggled. Each step of every operation lasts one half period of `CLK_FREQ_HZ / 10000` system cycles. At the default rate this gives roughly 100 µs per half period. The operations keep the clock low whenever the data line has to move, except in START and STOP.

Top module: `i2c_byte_master`

## Requirements
- R1: Every line step lasts exactly H = CLK_FREQ_HZ/10000 cycles. The edge that accepts a command is followed by one dispatch cycle and then by the step sequence, so `done` is high on edge 1 + S·H after acceptance. S is 2 for PROBE and START, 3 for STOP, 18 for WRITE and 19 for READ.
- R2: The data-line value bits of `lineOut` are always 0. A data 0 is made by setting the data-line enable bit, and a data 1 is made by clearing it.
- R3: Bus n uses bit 2n for its clock line and bit 2n+1 for its data line in `lineOut`, `lineOe` and `lineIn`. A command touches only the bits of its own bus.
- R4: PROBE (`cmdOp` = 0) makes the clock line high and enabled and releases the data line. After two steps it sets `status` to the data-line level read back. The clock enable of a bus never drops once it is set.
- R5: START (`cmdOp` = 1) sets the clock high for one step. It then enables the data line (pulls it low) for one step.
- R6: STOP (`cmdOp` = 2) drives the clock low for one step, then pulls the data line low with the clock high for one step, then releases the data line for one step.
- R7: WRITE (`cmdOp` = 3) sends `txByte` MSB first. Each bit is a clock-low step with the data line set, followed by a clock-high step. A ninth clock pulse follows, with the data line released. `status` becomes 1 if the data line reads low at the end of that ninth clock-high step.
- R8: READ (`cmdOp` = 4) first drives the clock low for one step before it releases the data line. It samples 8 bits MSB first at the end of each clock-high step into `rxByte`. It then gives a ninth pulse with the data line pulled low only when `ackReq` was 1. The data line never changes while the clock stays high during WRITE or READ.
- R9: For a bus index at or above NUM_BUSES, the data line reads as 1 and no line bit changes. As a result, PROBE reports 1, WRITE reports 0 and READ returns 8'hFF.
- R10: `busy` is high from the cycle after acceptance until `done`. `done` lasts one cycle, with `busy` low. A strobe while busy, or with `cmdOp` 5 to 7, is ignored. Line bits change only while busy.
- R11: After reset, `lineOut`, `lineOe`, `rxByte`, `status`, `busy` and `done` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Start strobe for a command |
| cmdOp | input | 3 | Operation: 0 probe, 1 start, 2 stop, 3 write, 4 read |
| busSel | input | BUS_IDX_W | Target bus index |
| txByte | input | 8 | Byte to send for WRITE |
| ackReq | input | 1 | READ acknowledges the byte when 1 |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| rxByte | output | 8 | Byte received by READ |
| status | output | 1 | PROBE: bus ready; WRITE: acknowledged |
| lineOut | output | 2·NUM_BUSES | Line values, clock at 2n, data at 2n+1 |
| lineOe | output | 2·NUM_BUSES | Line enables, same layout |
| lineIn | input | 2·NUM_BUSES | Line levels read back, same layout |

## Verification
The bench builds the block with NUM_BUSES = 2 and BUS_IDX_W = 2. Indices 2 and 3 therefore exist on the port but map to no bus, which brings the out-of-range path within reach. CLK_FREQ_HZ = 40000 gives a four-cycle half period, so every one of the 256 byte values can be written on one bus and read back through a modelled target on the other at low cycle cost. The full cycle count and the per-step line states are compared against arithmetic expectations. A line monitor flags any data-line movement under a high clock outside START and STOP.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  typedef enum logic [2:0] {
    OP_PROBE = 3'd0,
    OP_START = 3'd1,
    OP_STOP  = 3'd2,
    OP_WRITE = 3'd3,
    OP_READ  = 3'd4
  } opCode_t;

  // strobes from the sequencer to the line datapath, valid for one cycle
  typedef struct packed {
    logic loadCmd;
    logic timerRestart;
    logic sclHigh;
    logic sclLow;
    logic sclEnable;
    logic sdaPull;
    logic sdaRelease;
    logic sdaFromTx;
    logic sdaPullIfAck;
    logic shiftTx;
    logic sampleRx;
    logic latchReady;
    logic latchAck;
    logic finish;
  } lineCtl_t;

endpackage

// File: rtl/i2cm_ctrl.sv
module i2cm_ctrl
  import i2cm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [2:0] cmdOp,
  input  logic       tick,
  output lineCtl_t   ctl,
  output logic       busy
);

  typedef enum logic [4:0] {
    S_IDLE, S_DISPATCH,
    S_PROBE_A, S_PROBE_B,
    S_START_A, S_START_B,
    S_STOP_A, S_STOP_B, S_STOP_C,
    S_WR_LO, S_WR_HI, S_WR_ACK_LO, S_WR_ACK_HI,
    S_RD_PRE, S_RD_LO, S_RD_HI, S_RD_ACK_LO, S_RD_ACK_HI
  } seqState_t;

  seqState_t state, nextState;
  opCode_t   opReg;
  logic [2:0] bitCnt;
  logic       bitLoad, bitDec;
  logic       opKnown;

  assign opKnown = (cmdOp <= 3'd4);
  assign busy    = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      opReg  <= OP_PROBE;
      bitCnt <= 3'd0;
    end else begin
      state <= nextState;
      if (ctl.loadCmd) opReg <= opCode_t'(cmdOp);
      if (bitLoad) bitCnt <= 3'd7;
      else if (bitDec) bitCnt <= bitCnt - 3'd1;
    end
  end

  always_comb begin
    nextState = state;
    ctl       = '0;
    bitLoad   = 1'b0;
    bitDec    = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (cmdValid && opKnown) begin
          ctl.loadCmd = 1'b1;
          nextState   = S_DISPATCH;
        end
      end
      S_DISPATCH: begin
        ctl.timerRestart = 1'b1;
        bitLoad          = 1'b1;
        unique case (opReg)
          OP_PROBE: begin
            ctl.sclHigh    = 1'b1;
            ctl.sclEnable  = 1'b1;
            ctl.sdaRelease = 1'b1;
            nextState      = S_PROBE_A;
          end
          OP_START: begin
            ctl.sclHigh = 1'b1;
            nextState   = S_START_A;
          end
          OP_STOP: begin
            ctl.sclLow = 1'b1;
            nextState  = S_STOP_A;
          end
          OP_WRITE: begin
            ctl.sclLow    = 1'b1;
            ctl.sdaFromTx = 1'b1;
            nextState     = S_WR_LO;
          end
          default: begin
            ctl.sclLow = 1'b1;
            nextState  = S_RD_PRE;
          end
        endcase
      end
      S_PROBE_A: if (tick) begin
        ctl.timerRestart = 1'b1;
        nextState        = S_PROBE_B;
      end
      S_PROBE_B: if (tick) begin
        ctl.latchReady = 1'b1;
        ctl.finish     = 1'b1;
        nextState      = S_IDLE;
      end
      S_START_A: if (tick) begin
        ctl.timerRestart = 1'b1;
        ctl.sdaPull      = 1'b1;
        nextState        = S_START_B;
      end
      S_START_B: if (tick) begin
        ctl.finish = 1'b1;
        nextState  = S_IDLE;
      end
      S_STOP_A: if (tick) begin
        ctl.timerRestart = 1'b1;
        ctl.sdaPull      = 1'b1;
        ctl.sclHigh      = 1'b1;
        nextState        = S_STOP_B;
      end
      S_STOP_B: if (tick) begin
        ctl.timerRestart = 1'b1;
        ctl.sdaRelease   = 1'b1;
        nextState        = S_STOP_C;
      end
      S_STOP_C: if (tick) begin
        ctl.finish = 1'b1;
        nextState  = S_IDLE;
      end
      S_WR_LO: if (tick) begin
        ctl.timerRestart = 1'b1;
        ctl.sclHigh      = 1'b1;
        ctl.shiftTx      = 1'b1;
        nextState        = S_WR_HI;
      end
      S_WR_HI: if (tick) begin
        ctl.timerRestart = 1'b1;
        ctl.sclLow       = 1'b1;
        if (bitCnt != 3'd0) begin
          ctl.sdaFromTx = 1'b1;
          bitDec        = 1'b1;
          nextState     = S_WR_LO;
        end else begin
          nextState = S_WR_ACK_LO;
        end
      end
      S_WR_ACK_LO: if (tick) begin
        ctl.timerRestart = 1'b1;
        ctl.sdaRelease   = 1'b1;
        ctl.sclHigh      = 1'b1;
        nextState        = S_WR_ACK_HI;
      end
      S_WR_ACK_HI: if (tick) begin
        ctl.latchAck = 1'b1;
        ctl.finish   = 1'b1;
        nextState    = S_IDLE;
      end
      S_RD_PRE: if (tick) begin
        ctl.timerRestart = 1'b1;
        ctl.sdaRelease   = 1'b1;
        nextState        = S_RD_LO;
      end
      S_RD_LO: if (tick) begin
        ctl.timerRestart = 1'b1;
        ctl.sclHigh      = 1'b1;
        nextState        = S_RD_HI;
      end
      S_RD_HI: if (tick) begin
        ctl.timerRestart = 1'b1;
        ctl.sampleRx     = 1'b1;
        ctl.sclLow       = 1'b1;
        if (bitCnt != 3'd0) begin
          bitDec    = 1'b1;
          nextState = S_RD_LO;
        end else begin
          ctl.sdaPullIfAck = 1'b1;
          nextState        = S_RD_ACK_LO;
        end
      end
      S_RD_ACK_LO: if (tick) begin
        ctl.timerRestart = 1'b1;
        ctl.sclHigh      = 1'b1;
        nextState        = S_RD_ACK_HI;
      end
      S_RD_ACK_HI: if (tick) begin
        ctl.finish = 1'b1;
        nextState  = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

endmodule

// File: rtl/i2cm_datapath.sv
module i2cm_datapath
  import i2cm_pkg::*;
#(
  parameter int NUM_BUSES   = 1,
  parameter int BUS_IDX_W   = 3,
  parameter int HALF_CYCLES = 10000
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  lineCtl_t               ctl,
  input  logic [BUS_IDX_W-1:0]   busSel,
  input  logic [7:0]             txByte,
  input  logic                   ackReq,
  input  logic [2*NUM_BUSES-1:0] lineIn,
  output logic                   tick,
  output logic [2*NUM_BUSES-1:0] lineOut,
  output logic [2*NUM_BUSES-1:0] lineOe,
  output logic [7:0]             rxByte,
  output logic                   status,
  output logic                   done
);

  localparam int CNT_W = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_CYCLES - 1);

  logic [CNT_W-1:0]     halfCnt;
  logic [BUS_IDX_W-1:0] busReg;
  logic [7:0]           txShift;
  logic [7:0]           rxShift;
  logic                 ackReg;
  logic                 statusReg;
  logic                 doneReg;
  logic                 sdaIn;

  // half-period step timer, saturating at its last count
  always_ff @(posedge clk) begin
    if (!rstN) halfCnt <= '0;
    else if (ctl.timerRestart) halfCnt <= '0;
    else if (halfCnt != CNT_LAST) halfCnt <= halfCnt + 1'b1;
  end
  assign tick = (halfCnt == CNT_LAST);

  // data-line readback of the selected bus; absent buses read as released
  always_comb begin
    sdaIn = 1'b1;
    for (int n = 0; n < NUM_BUSES; n++) begin
      if (busReg == BUS_IDX_W'(n)) sdaIn = lineIn[2*n+1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busReg    <= '0;
      txShift   <= '0;
      ackReg    <= 1'b0;
      rxShift   <= '0;
      statusReg <= 1'b0;
      doneReg   <= 1'b0;
    end else begin
      doneReg <= ctl.finish;
      if (ctl.loadCmd) begin
        busReg  <= busSel;
        txShift <= txByte;
        ackReg  <= ackReq;
      end
      if (ctl.shiftTx)  txShift <= {txShift[6:0], 1'b0};
      if (ctl.sampleRx) rxShift <= {rxShift[6:0], sdaIn};
      if (ctl.latchReady) statusReg <= sdaIn;
      if (ctl.latchAck)   statusReg <= ~sdaIn;
    end
  end

  generate
    for (genvar n = 0; n < NUM_BUSES; n++) begin : g_bus
      logic sclLevel, sclDrive, sdaDrive;
      logic hit;
      assign hit = (busReg == BUS_IDX_W'(n));

      always_ff @(posedge clk) begin
        if (!rstN) begin
          sclLevel <= 1'b0;
          sclDrive <= 1'b0;
          sdaDrive <= 1'b0;
        end else if (hit) begin
          if (ctl.sclHigh)   sclLevel <= 1'b1;
          if (ctl.sclLow)    sclLevel <= 1'b0;
          if (ctl.sclEnable) sclDrive <= 1'b1;
          if (ctl.sdaPull)                    sdaDrive <= 1'b1;
          else if (ctl.sdaRelease)            sdaDrive <= 1'b0;
          else if (ctl.sdaFromTx)             sdaDrive <= ~txShift[7];
          else if (ctl.sdaPullIfAck && ackReg) sdaDrive <= 1'b1;
        end
      end

      assign lineOut[2*n]   = sclLevel;
      assign lineOut[2*n+1] = 1'b0;
      assign lineOe[2*n]    = sclDrive;
      assign lineOe[2*n+1]  = sdaDrive;
    end
  endgenerate

  assign rxByte = rxShift;
  assign status = statusReg;
  assign done   = doneReg;

endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2cm_pkg::*;
#(
  parameter int NUM_BUSES   = 1,
  parameter int BUS_IDX_W   = 3,
  parameter int CLK_FREQ_HZ = 100_000_000
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cmdValid,
  input  logic [2:0]             cmdOp,
  input  logic [BUS_IDX_W-1:0]   busSel,
  input  logic [7:0]             txByte,
  input  logic                   ackReq,
  output logic                   busy,
  output logic                   done,
  output logic [7:0]             rxByte,
  output logic                   status,
  output logic [2*NUM_BUSES-1:0] lineOut,
  output logic [2*NUM_BUSES-1:0] lineOe,
  input  logic [2*NUM_BUSES-1:0] lineIn
);

  localparam int HALF_RAW    = CLK_FREQ_HZ / 10000;
  localparam int HALF_CYCLES = (HALF_RAW < 1) ? 1 : HALF_RAW;

  lineCtl_t ctl;
  logic     tick;

  i2cm_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .tick     (tick),
    .ctl      (ctl),
    .busy     (busy)
  );

  i2cm_datapath #(
    .NUM_BUSES   (NUM_BUSES),
    .BUS_IDX_W   (BUS_IDX_W),
    .HALF_CYCLES (HALF_CYCLES)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .busSel  (busSel),
    .txByte  (txByte),
    .ackReq  (ackReq),
    .lineIn  (lineIn),
    .tick    (tick),
    .lineOut (lineOut),
    .lineOe  (lineOe),
    .rxByte  (rxByte),
    .status  (status),
    .done    (done)
  );

endmodule

// File: rtl/i2c_byte_master_chk.sv
module i2c_byte_master_chk #(
  parameter int NUM_BUSES = 1
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   busy,
  input logic                   done,
  input logic [2*NUM_BUSES-1:0] lineOut,
  input logic [2*NUM_BUSES-1:0] lineOe
);

  function automatic logic [2*NUM_BUSES-1:0] laneMask(input int odd);
    logic [2*NUM_BUSES-1:0] m;
    m = '0;
    for (int n = 0; n < NUM_BUSES; n++) m[2*n+odd] = 1'b1;
    return m;
  endfunction

  localparam logic [2*NUM_BUSES-1:0] SCL_MASK = laneMask(0);
  localparam logic [2*NUM_BUSES-1:0] SDA_MASK = laneMask(1);

  // R2: data lines are only ever released or pulled, never driven high
  assert_sda_value_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (lineOut & SDA_MASK) == '0);

  // R4: a clock-line enable, once set, stays set
  assert_scl_enable_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((SCL_MASK & $past(lineOe) & ~lineOe) == '0));

  // R10: completion pulse lasts one cycle
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10: completion is reported with the sequencer idle
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R10: no line bit moves out of an idle cycle
  assert_lines_quiet_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> ($stable(lineOut) && $stable(lineOe)));

endmodule

bind i2c_byte_master i2c_byte_master_chk #(.NUM_BUSES(NUM_BUSES)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .busy    (busy),
  .done    (done),
  .lineOut (lineOut),
  .lineOe  (lineOe)
);

// File: tb/i2c_byte_master_bench.sv
`timescale 1ns/1ps
module i2c_byte_master_bench;

  localparam int NB    = 2;
  localparam int BW    = 2;
  localparam int FREQ  = 40000;
  localparam int H     = FREQ / 10000;
  localparam int LW    = 2 * NB;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cmdValid = 1'b0;
  logic [2:0]    cmdOp = 3'd0;
  logic [BW-1:0] busSel = '0;
  logic [7:0]    txByte = 8'h00;
  logic          ackReq = 1'b0;
  logic          busy, done, status;
  logic [7:0]    rxByte;
  logic [LW-1:0] lineOut, lineOe, lineIn;

  always #2.5 clk = ~clk;

  i2c_byte_master #(.NUM_BUSES(NB), .BUS_IDX_W(BW), .CLK_FREQ_HZ(FREQ)) u_i2c_byte_master (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .busSel(busSel),
    .txByte(txByte), .ackReq(ackReq), .busy(busy), .done(done), .rxByte(rxByte),
    .status(status), .lineOut(lineOut), .lineOe(lineOe), .lineIn(lineIn)
  );

  // target model on the watched bus
  int   tBus = 0;
  logic pull = 1'b0;
  logic stuck = 1'b0;
  int   slaveMode = 0;   // 0 idle, 1 write target, 2 read target
  logic slaveAck = 1'b0;
  logic [7:0] slaveData = 8'h00;
  int   falls = 0;
  int   rises = 0;
  logic [8:0] seenBits;
  logic prevScl = 1'b1, prevSda = 1'b1;
  logic allowEdge = 1'b0;
  int   glitches = 0;

  always_comb begin
    for (int n = 0; n < NB; n++) begin
      lineIn[2*n]   = lineOe[2*n] ? lineOut[2*n] : 1'b1;
      lineIn[2*n+1] = !lineOe[2*n+1] && !((n == tBus) && (pull || stuck));
    end
  end

  always @(negedge clk) begin
    logic curScl, curSda;
    int nf;
    curScl = lineIn[2*tBus];
    curSda = lineIn[2*tBus+1];
    if (prevScl && curScl && (curSda != prevSda) && !allowEdge) glitches++;
    if (!prevScl && curScl && rises < 9) begin
      seenBits[8-rises] = curSda;
      rises++;
    end
    if (prevScl && !curScl) begin
      nf = falls + 1;
      falls = nf;
      if (slaveMode == 1)      pull = (nf == 9) && slaveAck;
      else if (slaveMode == 2) pull = (nf >= 1 && nf <= 8) ? ~slaveData[8-nf] : 1'b0;
      else                     pull = 1'b0;
    end
    prevScl = lineIn[2*tBus];
    prevSda = lineIn[2*tBus+1];
  end

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s", req, what);
    end
  endtask

  // per-cycle record of the watched bus lines during a command
  logic traceScl [0:255];
  logic traceSda [0:255];
  int   lastCyc;

  function automatic int stepsOf(input int op);
    case (op)
      0: return 2; 1: return 2; 2: return 3; 3: return 18; default: return 19;
    endcase
  endfunction

  task automatic runCmd(input int op, input int bus, input logic [7:0] tx,
                        input bit ack, input int intrudeAt);
    int cyc;
    rises = 0; falls = 0;
    allowEdge = (op <= 2);
    @(negedge clk);
    cmdOp = 3'(op); busSel = BW'(bus); txByte = tx; ackReq = ack; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    cyc = 0;
    while (!done && cyc < 250) begin
      @(negedge clk);
      cyc++;
      traceScl[cyc] = lineOe[2*tBus] ? lineOut[2*tBus] : 1'b1;
      traceSda[cyc] = lineOe[2*tBus+1];
      if (cyc == intrudeAt) begin
        cmdOp = 3'd2; cmdValid = 1'b1;
      end else begin
        cmdValid = 1'b0;
      end
    end
    cmdValid = 1'b0;
    lastCyc = cyc;
    if (cyc >= 250) check(1'b0, "R10", "watchdog expired waiting for done");
    check(cyc == 1 + stepsOf(op) * H, "R1",
          $sformatf("op %0d duration actual %0d expected %0d", op, cyc, 1 + stepsOf(op) * H));
    @(negedge clk);
    check(!done && !busy, "R10", $sformatf("after done actual done=%b busy=%b expected 0 0", done, busy));
    allowEdge = 1'b0;
  endtask

  task automatic stepIs(input int k, input logic scl, input logic sdaOe, input string req);
    check(traceScl[1 + k*H] == scl && traceSda[1 + k*H] == sdaOe &&
          traceScl[(k+1)*H] == scl && traceSda[(k+1)*H] == sdaOe, req,
          $sformatf("step %0d actual scl=%b sdaOe=%b expected scl=%b sdaOe=%b",
                    k, traceScl[1 + k*H], traceSda[1 + k*H], scl, sdaOe));
  endtask

  initial begin : main
    logic [LW-1:0] saveOut, saveOe;
    bit sawBusy;
    repeat (3) @(negedge clk);
    // R11: reset state
    check(lineOut == '0 && lineOe == '0, "R11", $sformatf("lines actual %b/%b expected 0/0", lineOut, lineOe));
    check(!busy && !done && rxByte == 8'h00 && !status, "R11",
          $sformatf("outputs actual busy=%b done=%b rx=%h st=%b expected 0", busy, done, rxByte, status));
    rstN = 1'b1;
    @(negedge clk);

    // R10: undefined codes are ignored
    for (int op = 5; op < 8; op++) begin
      cmdOp = 3'(op); cmdValid = 1'b1;
      @(negedge clk); cmdValid = 1'b0;
      sawBusy = 0;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (busy || done) sawBusy = 1;
      end
      check(!sawBusy && lineOe == '0, "R10", $sformatf("code %0d actual busy/done seen=%b expected 0", op, sawBusy));
    end

    // R4 / R3: probe both buses
    tBus = 0;
    runCmd(0, 0, 8'h00, 0, -1);
    stepIs(0, 1'b1, 1'b0, "R4");
    stepIs(1, 1'b1, 1'b0, "R4");
    check(status == 1'b1, "R4", $sformatf("probe status actual %b expected 1", status));
    check(lineOe == 4'b0001 && lineOut == 4'b0001, "R3",
          $sformatf("bus0 lines actual %b/%b expected 0001/0001", lineOut, lineOe));
    tBus = 1;
    runCmd(0, 1, 8'h00, 0, -1);
    check(lineOe == 4'b0101 && lineOut == 4'b0101, "R3",
          $sformatf("bus1 lines actual %b/%b expected 0101/0101", lineOut, lineOe));
    check((lineOut & 4'b1010) == 4'b0000, "R2", $sformatf("data value bits actual %b expected 00", {lineOut[3], lineOut[1]}));
    stuck = 1'b1;
    runCmd(0, 1, 8'h00, 0, -1);
    check(status == 1'b0, "R4", $sformatf("stuck-low probe status actual %b expected 0", status));
    stuck = 1'b0;

    // R5 / R6 / R7: start, full write sweep on bus 0
    tBus = 0;
    runCmd(1, 0, 8'h00, 0, -1);
    stepIs(0, 1'b1, 1'b0, "R5");
    stepIs(1, 1'b1, 1'b1, "R5");
    slaveMode = 1;
    for (int b = 0; b < 256; b++) begin
      slaveAck = (b % 3) != 0;
      runCmd(3, 0, 8'(b), 0, -1);
      check(seenBits[8:1] == 8'(b), "R7", $sformatf("bits on line actual %h expected %h", seenBits[8:1], 8'(b)));
      check(status == slaveAck, "R7", $sformatf("ack status actual %b expected %b", status, slaveAck));
      if (b == 8'h5A) begin
        stepIs(0, 1'b0, 1'b1, "R7");
        stepIs(1, 1'b1, 1'b1, "R7");
        stepIs(2, 1'b0, 1'b0, "R7");
        stepIs(17, 1'b1, 1'b0, "R7");
      end
    end
    // R10: strobe while busy is ignored
    slaveAck = 1'b1;
    runCmd(3, 0, 8'hA5, 0, 5);
    check(seenBits[8:1] == 8'hA5 && status, "R10",
          $sformatf("busy strobe write actual %h/%b expected a5/1", seenBits[8:1], status));
    slaveMode = 0;
    runCmd(2, 0, 8'h00, 0, -1);
    stepIs(0, 1'b0, 1'b0, "R6");
    stepIs(1, 1'b1, 1'b1, "R6");
    stepIs(2, 1'b1, 1'b0, "R6");

    // R8: full read sweep on bus 1
    tBus = 1;
    prevScl = 1'b1; prevSda = 1'b1;
    runCmd(1, 1, 8'h00, 0, -1);
    slaveMode = 2;
    for (int d = 0; d < 256; d++) begin
      slaveData = 8'(d);
      runCmd(4, 1, 8'h00, d[1], -1);
      check(rxByte == 8'(d), "R8", $sformatf("read byte actual %h expected %h", rxByte, 8'(d)));
      check(traceScl[1] == 1'b0 && traceSda[1 + H] == 1'b0 && traceScl[1 + H] == 1'b0, "R8",
            $sformatf("release order actual scl0=%b sda1=%b expected 0 0", traceScl[1], traceSda[1 + H]));
      check(traceSda[1 + 17*H] == d[1] && traceScl[1 + 18*H] == 1'b1, "R8",
            $sformatf("ack drive actual %b expected %b", traceSda[1 + 17*H], d[1]));
    end
    slaveMode = 0;
    runCmd(2, 1, 8'h00, 0, -1);
    check(glitches == 0, "R8", $sformatf("data moves under high clock actual %0d expected 0", glitches));

    // R9: absent buses
    for (int bi = NB; bi < (1 << BW); bi++) begin
      saveOut = lineOut; saveOe = lineOe;
      runCmd(0, bi, 8'h00, 0, -1);
      check(status == 1'b1, "R9", $sformatf("probe absent actual %b expected 1", status));
      runCmd(3, bi, 8'h00, 0, -1);
      check(status == 1'b0, "R9", $sformatf("write absent ack actual %b expected 0", status));
      runCmd(4, bi, 8'h00, 1, -1);
      check(rxByte == 8'hFF, "R9", $sformatf("read absent actual %h expected ff", rxByte));
      check(lineOut == saveOut && lineOe == saveOe, "R9",
            $sformatf("lines actual %b/%b expected %b/%b", lineOut, lineOe, saveOut, saveOe));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R10 watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule